// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a two-wire bus EEPROM slave with a 256-byte array. A fast system clock oversamples the bus clock and data lines. Both lines pass through a synchronizer and a three-sample majority filter. The block then detects bus conditions, decodes the device address word, and drives the data line only through an open-drain pull-down enable.

A write transaction gives a word address and then up to eight data bytes, which are gathered in a page buffer. After a clean STOP the buffered bytes are written to the array one per system clock. Each written byte is also reported to an external write-cycle controller as a single-cycle request. While that controller reports busy, the slave refuses every device address, so a master can poll for completion. Three read forms are supported. A current-address read uses the internal counter. A random read is a write header followed by a repeated START. A sequential read continues for as long as the master acknowledges.

Top module: `eeprom_slave`

## Requirements
- R1: A transfer begins only with a START (data falls while clock is high) and is ended by a STOP (data rises while clock is high). Bytes clocked while no transfer is active get no response.
- R2: A device address word is accepted only when its top four bits are 1010 and the next three bits equal strap_i[2:1:0]. Bit 0 selects read (1) or write (0). On a mismatch the slave never drives SDA until the next START.
- R3: After each accepted address byte and each received data byte, sda_oe_o is high for the whole ninth clock, from the eighth falling edge of SCL to the ninth falling edge.
- R4: In a write, the byte after the device address loads the word address counter. Each data byte is stored at the counter, and only the counter's low 3 bits then increment, so a ninth byte wraps to the start of the same 8-byte page.
- R5: A STOP that follows a fully acknowledged data byte commits the buffered page. The commit issues one wr_req_o pulse, with wr_addr_o and wr_data_o, for each distinct byte position written. A STOP in the middle of a byte discards the whole page.
- R6: When wp_i is high at the committing STOP, no wr_req_o is issued and the array is unchanged.
- R7: While wr_busy_i is high, or a commit is still in progress, no device address is acknowledged.
- R8: A read started without a word address returns the byte at the counter, which is the last accessed address plus one. Bits go out MSB first and change only after SCL falls.
- R9: A sequential read continues while the master acknowledges and wraps from 0xFF to 0x00. A master no-acknowledge ends it, and SDA is released.
- R10: After reset, sda_oe_o and wr_req_o are low, the counter is 0 and the array holds zeros.
- R11: A pulse on SCL that lasts a single system clock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, well above the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Hard-wired device select bits |
| wp_i | input | 1 | Write inhibit, high blocks commits |
| wr_busy_i | input | 1 | Write-cycle controller busy |
| sda_oe_o | output | 1 | High pulls the data line low |
| wr_req_o | output | 1 | One-cycle byte write request |
| wr_addr_o | output | 8 | Address of the requested byte write |
| wr_data_o | output | 8 | Data of the requested byte write |

## Verification
Every byte of the array is written through full pages and read back in one sequential read. That read starts at 0xFE, so a counter that saturates, or that wraps at the page in read mode, returns the wrong bytes. A ten-byte page write that starts three bytes before the page end exposes a counter that carries into the upper bits, or a commit that issues more than one request per position. A partial byte before STOP, a STOP under write inhibit and polling during busy each catch a design that commits data it should drop or that acknowledges too early. A one-clock SCL glitch inside a data byte catches a missing filter, because the glitch shifts an extra bit into the byte.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WR, ST_RD, ST_RACK
  } state_e;
endpackage

// File: rtl/eeprom_filter.sv
module eeprom_filter #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC-1:0] sync_q;
  logic [2:0]      hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], line_i};
      hist_q <= {hist_q[1:0], sync_q[SYNC-1]};
    end
  end

  assign line_o = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int unsigned AW   = 8,  // at most 8
  parameter int unsigned PW   = 3,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          wp_i,
  input  logic          wr_busy_i,
  output logic          sda_oe_o,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int unsigned PAGE = 1 << PW;
  localparam int unsigned HW   = AW - PW;

  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    eeprom_filter #(.SYNC(SYNC)) u_flt (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(raw[g]), .line_o(filt[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  logic scl_rise, scl_fall, start_w, stop_w;
  assign scl_f    = filt[0];
  assign sda_f    = filt[1];
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_w  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_w   = scl_f & scl_q & ~sda_q & sda_f;

  state_e              st_q;
  logic                ack_q, rw_q, mack_q, oe_q, commit_q;
  logic [3:0]          cnt_q;
  logic [BYTE_W-1:0]   sh_q, rd_data;
  logic [AW-1:0]       addr_q;
  logic [HW-1:0]       page_q;
  logic [BYTE_W-1:0]   buf_q [PAGE];
  logic [PAGE-1:0]     pend_q;
  logic [PW-1:0]       cidx_q, slot;
  logic                busy_w, dev_hit, clean_end;

  assign slot      = addr_q[PW-1:0];
  assign busy_w    = wr_busy_i | commit_q;
  assign dev_hit   = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i);
  // the STOP's own rising clock adds one bit after the ack slot
  assign clean_end = (st_q == ST_WR) && !ack_q && (cnt_q <= 4'd1);

  assign wr_req_o  = commit_q & pend_q[cidx_q];
  assign wr_addr_o = {page_q, cidx_q};
  assign wr_data_o = buf_q[cidx_q];
  assign sda_oe_o  = oe_q;

  eeprom_store #(.AW(AW), .DW(BYTE_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_req_o), .waddr_i(wr_addr_o),
    .wdata_i(wr_data_o), .raddr_i(addr_q), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ack_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0; oe_q <= 1'b0;
      commit_q <= 1'b0; cnt_q <= '0; sh_q <= '0; addr_q <= '0; page_q <= '0;
      pend_q <= '0; cidx_q <= '0;
      for (int i = 0; i < PAGE; i++) buf_q[i] <= '0;
    end else begin
      if (commit_q) begin
        cidx_q <= cidx_q + 1'b1;
        if (cidx_q == PW'(PAGE - 1)) begin
          commit_q <= 1'b0;
          pend_q   <= '0;
        end
      end
      if (start_w) begin
        st_q <= ST_DEV; cnt_q <= '0; ack_q <= 1'b0; oe_q <= 1'b0;
        if (!commit_q) pend_q <= '0;
      end else if (stop_w) begin
        st_q <= ST_IDLE; cnt_q <= '0; ack_q <= 1'b0; oe_q <= 1'b0;
        if (clean_end && pend_q != '0 && !wp_i && !commit_q) begin
          commit_q <= 1'b1;
          cidx_q   <= '0;
          page_q   <= addr_q[AW-1:PW];
        end else if (!commit_q) begin
          pend_q <= '0;
        end
      end else if (scl_rise) begin
        unique case (st_q)
          ST_DEV, ST_ADDR, ST_WR: if (!ack_q) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
            cnt_q <= cnt_q + 4'd1;
          end
          ST_RD: cnt_q <= cnt_q + 4'd1;
          ST_RACK: begin
            mack_q <= ~sda_f;
            cnt_q  <= cnt_q + 4'd1;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (st_q)
          ST_DEV: begin
            if (ack_q) begin
              ack_q <= 1'b0; oe_q <= 1'b0; cnt_q <= '0;
              if (rw_q) begin
                sh_q <= rd_data; oe_q <= ~rd_data[BYTE_W-1]; addr_q <= addr_q + 1'b1;
                st_q <= ST_RD;
              end else begin
                st_q <= ST_ADDR;
              end
            end else if (cnt_q == 4'd8) begin
              if (dev_hit && !busy_w) begin
                ack_q <= 1'b1; oe_q <= 1'b1; rw_q <= sh_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR: begin
            if (ack_q) begin
              ack_q <= 1'b0; oe_q <= 1'b0; cnt_q <= '0; st_q <= ST_WR;
            end else if (cnt_q == 4'd8) begin
              addr_q <= sh_q[AW-1:0]; ack_q <= 1'b1; oe_q <= 1'b1;
            end
          end
          ST_WR: begin
            if (ack_q) begin
              ack_q <= 1'b0; oe_q <= 1'b0; cnt_q <= '0;
            end else if (cnt_q == 4'd8) begin
              buf_q[slot]      <= sh_q;
              pend_q[slot]     <= 1'b1;
              addr_q[PW-1:0]   <= slot + 1'b1;
              ack_q <= 1'b1; oe_q <= 1'b1;
            end
          end
          ST_RD: begin
            if (cnt_q == 4'd8) begin
              st_q <= ST_RACK; oe_q <= 1'b0; cnt_q <= '0;
            end else begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q <= ~sh_q[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (cnt_q != '0) begin
              cnt_q <= '0;
              if (mack_q) begin
                sh_q <= rd_data; oe_q <= ~rd_data[BYTE_W-1]; addr_q <= addr_q + 1'b1;
                st_q <= ST_RD;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: idle slave never pulls the line
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  // R4: page row is frozen while data bytes arrive
  a_r4_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR && $past(st_q) == ST_WR) |-> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]));
  // R7: no address acknowledge granted while busy
  a_r7_busy_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEV && $rose(ack_q)) |-> !$past(busy_w));
  // R9: each acknowledged read byte advances the full-width counter
  a_r9_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD && $past(st_q) == ST_RACK) |-> addr_q == AW'($past(addr_q) + 1));
endmodule

// File: tb/sim_eeprom_slave.sv
`timescale 1ns/1ps
module sim_eeprom_slave;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, wr_req;
  logic [7:0] wr_addr, wr_data;
  logic sda_bus;
  int busy_cnt = 0;
  int reqs = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;
  bit glitch = 1'b0;
  logic [7:0] m [256];
  logic [7:0] rbuf [300];
  logic [7:0] wbuf [16];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  eeprom_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
    .wp_i(wp), .wr_busy_i(busy_cnt != 0), .sda_oe_o(sda_oe), .wr_req_o(wr_req),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    if (wr_req) begin
      busy_cnt <= 300;
      reqs <= reqs + 1;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic do_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic do_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask

  task automatic bit_out(logic b);
    sda_m = b;
    if (glitch) begin scl_m = 1; @(negedge clk); scl_m = 0; end
    wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq();
  endtask

  task automatic send_byte(logic [7:0] d, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic recv_byte(bit more, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
    bit_out(!more);
  endtask

  // write header + n bytes of wbuf; returns number of acks
  task automatic write_tx(int a, int n, bit commit, output int acks);
    bit k;
    acks = 0;
    do_start();
    send_byte(DEVW, k); acks += int'(k);
    send_byte(8'(a), k); acks += int'(k);
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], k); acks += int'(k); end
    do_stop();
    if (commit)
      for (int i = 0; i < n; i++) m[{a[7:3], 3'(a + i)}] = wbuf[i];
  endtask

  task automatic poll(output bit first);
    bit k;
    int tries = 0;
    do begin
      do_start(); send_byte(DEVW, k); do_stop();
      if (tries == 0) first = k;
      tries++;
    end while (!k && tries < 20);
  endtask

  task automatic read_tx(bit rnd, int a, int n, output bit acked);
    bit k;
    acked = 1;
    do_start();
    if (rnd) begin
      send_byte(DEVW, k); acked &= k;
      send_byte(8'(a), k); acked &= k;
      do_start();
    end
    send_byte(DEVR, k); acked &= k;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
  endtask

  initial begin
    repeat (10000 + 190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit k, f;
    int acks, r0;
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 oe at reset", int'(sda_oe), 0);
    chk("R10 req at reset", int'(wr_req), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R10: counter starts at 0, array zero
    read_tx(0, 0, 1, k);
    do_stop();
    chk("R10 current read after reset", int'(rbuf[0]), 0);

    // R2: wrong strap, then R1: byte without START ignored
    do_start();
    send_byte({4'b1010, ~STRAP, 1'b0}, k);
    chk("R2 strap mismatch nack", int'(k), 0);
    send_byte(DEVW, k);
    chk("R1 no response without START", int'(k), 0);
    do_stop();
    do_start();
    send_byte({4'b1011, STRAP, 1'b0}, k);
    chk("R2 code mismatch nack", int'(k), 0);
    do_stop();

    // sweep: every page written in full
    for (int p = 0; p < 32; p++) begin
      for (int i = 0; i < 8; i++) wbuf[i] = 8'((p * 8 + i) * 37 + 11);
      r0 = reqs;
      write_tx(p * 8, 8, 1, acks);
      chk("R3 acks per page", acks, 10);
      poll(f);
      chk("R7 poll nack while busy", int'(f), 0);
      chk("R5 requests per page", reqs - r0, 8);
    end

    // R9: sequential read over the whole array, crossing 0xFF -> 0x00
    read_tx(1, 8'hFE, 258, k);
    chk("R9 read header ack", int'(k), 1);
    chk("R9 released after nack", int'(sda_oe), 0);
    do_stop();
    for (int i = 0; i < 258; i++) chk("R9 sequential byte", int'(rbuf[i]), int'(m[8'(8'hFE + i)]));

    // R4: ten bytes from 0x1D wrap inside page 0x18
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'hC0 + i);
    r0 = reqs;
    write_tx(8'h1D, 10, 1, acks);
    chk("R4 acks on wrap", acks, 12);
    poll(f);
    chk("R5 one request per slot", reqs - r0, 8);
    // R8: counter = last written (0x1E) + 1
    read_tx(0, 0, 1, k);
    do_stop();
    chk("R8 current address read", int'(rbuf[0]), int'(m[8'h1F]));
    read_tx(1, 8'h18, 8, k);
    do_stop();
    for (int i = 0; i < 8; i++) chk("R4 page wrap content", int'(rbuf[i]), int'(m[8'h18 + i]));

    // R6: inhibited write
    wp = 1'b1;
    wbuf[0] = 8'h5A;
    r0 = reqs;
    write_tx(8'h50, 1, 0, acks);
    repeat (40) @(negedge clk);
    chk("R6 no request under wp", reqs - r0, 0);
    wp = 1'b0;
    read_tx(1, 8'h50, 1, k);
    do_stop();
    chk("R6 array unchanged", int'(rbuf[0]), int'(m[8'h50]));

    // R5: STOP inside a byte discards the page
    r0 = reqs;
    do_start();
    send_byte(DEVW, k); send_byte(8'h60, k); send_byte(8'h11, k);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    do_stop();
    repeat (40) @(negedge clk);
    chk("R5 aborted page no request", reqs - r0, 0);
    read_tx(1, 8'h60, 1, k);
    do_stop();
    chk("R5 aborted page content", int'(rbuf[0]), int'(m[8'h60]));

    // R11: one-clock SCL glitches during the data byte
    do_start();
    send_byte(DEVW, k); send_byte(8'h70, k);
    glitch = 1'b1;
    send_byte(8'h3C, k);
    glitch = 1'b0;
    do_stop();
    m[8'h70] = 8'h3C;
    poll(f);
    read_tx(1, 8'h70, 1, k);
    do_stop();
    chk("R11 glitch rejected", int'(rbuf[0]), 8'h3C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule